// File: doc/BRIEF.md
# Interrupt Throttle and Cause Controller

This block gathers interrupt causes from a network controller into one cause register and drives a single interrupt line to the host. The line is only raised when at least one cause bit that the host has enabled in the mask input is set. The block limits the assertion rate: once the line has been raised, another assertion is allowed only after a programmable interval has passed. The interval is counted from the moment of the last real assertion, not from when a new cause arrives. A cause that arrives too early arms a single deferred post that fires when the interval ends.

A free-running nanosecond time counter provides the time base. The interval input counts in 256 ns units. When the block actually raises the line, it takes over any pending receive or transmit delay timers. Each pending timer sets its own cause bit and receives a one-cycle cancel pulse. A host read strobe clears the whole cause register, and the line drops with it. If the mask leaves no enabled cause pending, the line drops and any deferred post is cancelled.

Top module: `irq_throttle`

## Requirements
- R1: Each nonzero `cause_set` bit is ORed into the cause register on the next clock edge. Set bits stay set until a read strobe clears them. After reset the register is zero and `irq` is low.
- R2: When `itr_ivl` is zero, a cause arrival with an enabled bit raises `irq` on the next clock edge.
- R3: When `post_now` is high with a cause arrival, the post happens on the next edge even inside the throttle interval.
- R4: If `itr_ivl` is nonzero, an arrival is posted at once only when last-assert time + `itr_ivl`×256 ns ≤ current time. Otherwise `irq` stays low until the current time reaches that deadline, and `irq` rises on the following edge.
- R5: Only one deferred post is armed at a time. Its deadline is fixed when it is armed. Later arrivals, or a change of `itr_ivl` while it is armed, do not move it.
- R6: A post attempt when (cause & `int_mask`) has no set bit, counting cause bits 0..CAUSE_W-2, does not raise `irq`, does not fold timers, emits no cancel pulse, and leaves the last-assert time unchanged.
- R7: A post that raises `irq` with `rx_tmr_pend` high sets cause bit 7 (RXT_BIT) and pulses `rx_tmr_cancel` for one cycle. With `tx_tmr_pend` high, it sets cause bit 0 (TXDW_BIT) and pulses `tx_tmr_cancel`. Both pulses are registered and coincide with the rise of `irq`.
- R8: Cause bit 31 (the top bit) is the asserted-status bit. It is set exactly when `irq` is high.
- R9: A `cause_rd` strobe clears the cause register and drops `irq` at the next edge. Causes arriving in the same cycle are kept.
- R10: When the mask leaves no enabled cause pending, `irq` drops on the next edge and any deferred post is cancelled. The cause bits themselves stay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_set | input | CAUSE_W | Cause bits arriving this cycle |
| post_now | input | 1 | Post without throttling |
| int_mask | input | CAUSE_W | Enable mask for cause bits |
| itr_ivl | input | ITR_W | Minimum interval between assertions, 256 ns units |
| cause_rd | input | 1 | Host read-to-clear strobe |
| rx_tmr_pend | input | 1 | Receive delay timer pending |
| tx_tmr_pend | input | 1 | Transmit delay timer pending |
| irq | output | 1 | Interrupt line |
| cause | output | CAUSE_W | Readable cause register |
| rx_tmr_cancel | output | 1 | One-cycle cancel for the receive timer |
| tx_tmr_cancel | output | 1 | One-cycle cancel for the transmit timer |

## Verification
All outputs are registered. An immediate post, a read-clear or a mask-driven drop therefore shows one edge after the input cycle, and the bench samples it at the following falling edge. A deferred post shows one edge after the cycle in which the time counter reaches the deadline. That deadline is 32 cycles after the last assertion for one interval unit at 8 ns per clock. The bench therefore checks that `irq` is still low a few cycles after an early cause and high well after the deadline. It also runs an edge-by-edge reference model and compares every output at each falling edge.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;
   typedef enum logic [1:0] {
      POST_NONE     = 2'd0,
      POST_DIRECT   = 2'd1,
      POST_DEFERRED = 2'd2
   } post_src_e;
endpackage

// File: rtl/irq_timebase.sv
module irq_timebase #(
   parameter int TIME_W     = 32,
   parameter int NS_PER_CLK = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TIME_W-1:0] now
);
   logic [TIME_W-1:0] now_q;

   generate
      if (NS_PER_CLK == 1) begin : g_unit
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) now_q <= '0;
            else        now_q <= now_q + 1'b1;
      end else begin : g_step
         localparam logic [TIME_W-1:0] STEP = TIME_W'(NS_PER_CLK);
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) now_q <= '0;
            else        now_q <= now_q + STEP;
      end
   endgenerate

   assign now = now_q;
endmodule

// File: rtl/irq_pace.sv
module irq_pace
   import irq_thr_pkg::*;
#(
   parameter int TIME_W    = 32,
   parameter int ITR_W     = 16,
   parameter int ITR_SHIFT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now,
   input  logic [ITR_W-1:0]  ivl,
   input  logic              post_now,
   input  logic              any_cause,
   input  logic              posted,
   input  logic              disarm,
   output logic              post_req,
   output post_src_e         post_src
);
   logic              armed_q;
   logic [TIME_W-1:0] deadline_q, last_q, span, limit;
   logic              due, fire;

   assign span  = TIME_W'(ivl) << ITR_SHIFT;
   assign limit = last_q + span;
   assign due   = (ivl == '0) || post_now || (limit <= now);
   assign fire  = armed_q && (now >= deadline_q);

   always_comb begin
      post_src = POST_NONE;
      if (any_cause && due) post_src = POST_DIRECT;
      else if (fire)        post_src = POST_DEFERRED;
   end
   assign post_req = (post_src != POST_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         deadline_q <= '0;
         last_q     <= '0;
      end else begin
         if (post_req) armed_q <= 1'b0;
         else if (any_cause && !armed_q) begin
            armed_q    <= 1'b1;
            deadline_q <= limit;
         end
         if (disarm) armed_q <= 1'b0;
         if (posted) last_q <= now;
      end
   end

   // R5
   deadline_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && !post_req && !disarm |=> $stable(deadline_q) && armed_q);

   // R4
   deadline_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> deadline_q > last_q);

   // R6
   masked_keeps_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      post_req && disarm |=> $stable(last_q));
endmodule

// File: rtl/irq_cause.sv
module irq_cause #(
   parameter int CAUSE_W  = 32,
   parameter int RXT_BIT  = 7,
   parameter int TXDW_BIT = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_W-1:0] cause_set,
   input  logic [CAUSE_W-1:0] mask,
   input  logic               rd_clr,
   input  logic               post_req,
   input  logic               rx_pend,
   input  logic               tx_pend,
   output logic [CAUSE_W-1:0] cause_q,
   output logic               posted,
   output logic               none_en,
   output logic               rx_cancel,
   output logic               tx_cancel
);
   localparam int ABIT = CAUSE_W - 1;
   localparam logic [CAUSE_W-1:0] A_ONE  = CAUSE_W'(1) << ABIT;
   localparam logic [CAUSE_W-1:0] SEL_EN = ~A_ONE;
   localparam logic [CAUSE_W-1:0] RX_ONE = CAUSE_W'(1) << RXT_BIT;
   localparam logic [CAUSE_W-1:0] TX_ONE = CAUSE_W'(1) << TXDW_BIT;

   logic [CAUSE_W-1:0] base, nxt;
   logic               en_base;

   always_comb begin
      base    = (rd_clr ? '0 : cause_q) | cause_set;
      en_base = |(base & mask & SEL_EN);
      posted  = post_req && en_base;
      nxt     = base;
      if (posted) begin
         nxt = nxt | A_ONE;
         if (rx_pend) nxt = nxt | RX_ONE;
         if (tx_pend) nxt = nxt | TX_ONE;
      end
      none_en = ~|(nxt & mask & SEL_EN);
      if (none_en) nxt[ABIT] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q   <= '0;
         rx_cancel <= 1'b0;
         tx_cancel <= 1'b0;
      end else begin
         cause_q   <= nxt;
         rx_cancel <= posted && rx_pend;
         tx_cancel <= posted && tx_pend;
      end
   end

   // R10
   line_needs_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cause_q[ABIT] |-> |(cause_q & $past(mask) & SEL_EN));

   // R9
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr && (cause_set == '0) && !post_req |=> (cause_q == '0));

   // R7
   rx_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cancel |-> cause_q[RXT_BIT] && cause_q[ABIT]);

   // R7
   tx_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cancel |-> cause_q[TXDW_BIT] && cause_q[ABIT]);
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle
   import irq_thr_pkg::*;
#(
   parameter int CAUSE_W    = 32,
   parameter int RXT_BIT    = 7,
   parameter int TXDW_BIT   = 0,
   parameter int TIME_W     = 32,
   parameter int ITR_W      = 16,
   parameter int ITR_SHIFT  = 8,
   parameter int NS_PER_CLK = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_W-1:0] cause_set,
   input  logic               post_now,
   input  logic [CAUSE_W-1:0] int_mask,
   input  logic [ITR_W-1:0]   itr_ivl,
   input  logic               cause_rd,
   input  logic               rx_tmr_pend,
   input  logic               tx_tmr_pend,
   output logic               irq,
   output logic [CAUSE_W-1:0] cause,
   output logic               rx_tmr_cancel,
   output logic               tx_tmr_cancel
);
   localparam int ABIT = CAUSE_W - 1;

   generate
      if (CAUSE_W < 3) begin : g_bad_w
         $error("CAUSE_W too small");
      end
      if (RXT_BIT >= ABIT || TXDW_BIT >= ABIT || RXT_BIT == TXDW_BIT) begin : g_bad_bits
         $error("timer cause bits misplaced");
      end
      if (ITR_W + ITR_SHIFT > TIME_W) begin : g_bad_time
         $error("TIME_W cannot hold the interval");
      end
      if (NS_PER_CLK < 1) begin : g_bad_step
         $error("NS_PER_CLK must be positive");
      end
   endgenerate

   logic [TIME_W-1:0]  now;
   logic [CAUSE_W-1:0] cause_q;
   logic               post_req, posted, none_en;
   post_src_e          post_src;

   irq_timebase #(.TIME_W(TIME_W), .NS_PER_CLK(NS_PER_CLK)) u_time (
      .clk(clk), .rst_n(rst_n), .now(now));

   irq_pace #(.TIME_W(TIME_W), .ITR_W(ITR_W), .ITR_SHIFT(ITR_SHIFT)) u_pace (
      .clk(clk), .rst_n(rst_n), .now(now), .ivl(itr_ivl), .post_now(post_now),
      .any_cause(|cause_set), .posted(posted), .disarm(none_en),
      .post_req(post_req), .post_src(post_src));

   irq_cause #(.CAUSE_W(CAUSE_W), .RXT_BIT(RXT_BIT), .TXDW_BIT(TXDW_BIT)) u_cause (
      .clk(clk), .rst_n(rst_n), .cause_set(cause_set), .mask(int_mask),
      .rd_clr(cause_rd), .post_req(post_req), .rx_pend(rx_tmr_pend),
      .tx_pend(tx_tmr_pend), .cause_q(cause_q), .posted(posted),
      .none_en(none_en), .rx_cancel(rx_tmr_cancel), .tx_cancel(tx_tmr_cancel));

   assign cause = cause_q;
   assign irq   = cause_q[ABIT];

   // R4
   rise_from_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(post_src) != POST_NONE);

   // R2
   direct_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (itr_ivl == '0) && (|(cause_set & int_mask & ~(CAUSE_W'(1) << ABIT))) |=> irq);
endmodule

// File: tb/irq_throttle_test.sv
module irq_throttle_test;
   localparam int CW = 32;
   localparam logic [31:0] ABIT = 32'h8000_0000;
   localparam logic [31:0] RXB  = 32'h0000_0080;
   localparam logic [31:0] TXB  = 32'h0000_0001;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [CW-1:0] cause_set = '0, int_mask = '0;
   logic post_now = 1'b0, cause_rd = 1'b0, rx_p = 1'b0, tx_p = 1'b0;
   logic [15:0] ivl = '0;
   logic irq, rxc, txc;
   logic [CW-1:0] cause;
   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_throttle uut (
      .clk(clk), .rst_n(rst_n), .cause_set(cause_set), .post_now(post_now),
      .int_mask(int_mask), .itr_ivl(ivl), .cause_rd(cause_rd),
      .rx_tmr_pend(rx_p), .tx_tmr_pend(tx_p), .irq(irq), .cause(cause),
      .rx_tmr_cancel(rxc), .tx_tmr_cancel(txc));

   // behavioural reference
   logic [31:0] m_cause, m_now, m_last, m_dl;
   bit m_arm, m_rx, m_tx;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cause = 0; m_now = 0; m_last = 0; m_dl = 0; m_arm = 0; m_rx = 0; m_tx = 0;
      end else begin
         logic [31:0] a;
         bit go, early;
         a = (cause_rd ? 32'h0 : m_cause) | cause_set;
         early = (ivl != 0) && !post_now && (m_last + 32'(ivl) * 256 > m_now);
         go = ((cause_set != 0) && !early) || (m_arm && m_now >= m_dl);
         m_rx = 0; m_tx = 0;
         if (go) begin
            m_arm = 0;
            if ((a & int_mask & ~ABIT) != 0) begin
               a = a | ABIT;
               if (rx_p) begin a = a | RXB; m_rx = 1; end
               if (tx_p) begin a = a | TXB; m_tx = 1; end
               m_last = m_now;
            end
         end else if (cause_set != 0 && !m_arm) begin
            m_arm = 1; m_dl = m_last + 32'(ivl) * 256;
         end
         if ((a & int_mask & ~ABIT) == 0) begin m_arm = 0; a = a & ~ABIT; end
         m_cause = a;
         m_now = m_now + 8;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) if (rst_n && !done) begin
      chk("R1 model cause", cause, m_cause);
      chk("R8 model irq", 32'(irq), 32'(m_cause[31]));
      chk("R7 model rx cancel", 32'(rxc), 32'(m_rx));
      chk("R7 model tx cancel", 32'(txc), 32'(m_tx));
   end

   task automatic pulse(logic [31:0] cs, bit pn, bit rd);
      @(negedge clk);
      cause_set = cs; post_now = pn; cause_rd = rd;
      @(negedge clk);
      cause_set = '0; post_now = 1'b0; cause_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #800000;
      tests++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      finish_up();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk("R1 reset cause", cause, 0);
      chk("R1 reset irq", 32'(irq), 0);
      int_mask = 32'h0000_00FF;
      // R2: interval zero, immediate
      pulse(32'h4, 0, 0);
      chk("R2 irq", 32'(irq), 1);
      chk("R8 cause", cause, 32'h4 | ABIT);
      pulse(32'h2, 0, 0);
      chk("R1 accumulate", cause, 32'h6 | ABIT);
      // R9
      pulse(0, 0, 1);
      chk("R9 cleared", cause, 0);
      chk("R9 irq low", 32'(irq), 0);
      // R4: deferred
      ivl = 16'd1;
      pulse(32'h8, 0, 0);
      idle(2);
      chk("R4 held off", 32'(irq), 0);
      chk("R4 cause kept", cause, 32'h8);
      idle(40);
      chk("R4 deferred post", 32'(irq), 1);
      // R5: deadline fixed
      pulse(0, 0, 1);
      pulse(32'h8, 0, 0);
      idle(2);
      ivl = 16'd8;
      pulse(32'h10, 0, 0);
      idle(3);
      chk("R5 still waiting", 32'(irq), 0);
      idle(35);
      chk("R5 original deadline", 32'(irq), 1);
      // R3
      pulse(0, 0, 1);
      pulse(32'h20, 1, 0);
      chk("R3 immediate", 32'(irq), 1);
      // R6: masked
      pulse(0, 0, 1);
      ivl = 16'd0;
      rx_p = 1'b1;
      pulse(32'h1000, 0, 0);
      chk("R6 no irq", 32'(irq), 0);
      chk("R6 no fold", cause, 32'h1000);
      chk("R6 no cancel", 32'(rxc), 0);
      // R7
      tx_p = 1'b1;
      pulse(32'h2, 0, 0);
      chk("R7 fold", cause, 32'h1000 | 32'h2 | RXB | TXB | ABIT);
      chk("R7 rx cancel", 32'(rxc), 1);
      chk("R7 tx cancel", 32'(txc), 1);
      rx_p = 1'b0; tx_p = 1'b0;
      idle(1);
      chk("R7 pulse ends", 32'(rxc | txc), 0);
      // R10: mask drop
      pulse(0, 0, 1);
      pulse(32'h4, 0, 0);
      chk("R10 setup", 32'(irq), 1);
      @(negedge clk); int_mask = '0;
      @(negedge clk);
      chk("R10 irq drop", 32'(irq), 0);
      chk("R10 cause kept", cause, 32'h4);
      // R10: deferred cancelled
      int_mask = 32'h0000_00FF;
      pulse(0, 0, 1);
      ivl = 16'd1;
      pulse(32'h4, 1, 0);
      pulse(0, 0, 1);
      pulse(32'h8, 0, 0);
      int_mask = '0;
      @(negedge clk); int_mask = 32'h0000_00FF;
      idle(50);
      chk("R10 deferred cancelled", 32'(irq), 0);
      chk("R10 cause after cancel", cause, 32'h8);
      idle(2);
      finish_up();
   end
endmodule